// File: doc/BRIEF.md
# 8b/10b Line Decoder

This block turns received 10-bit line characters back into bytes. It sits after comma alignment in a serial receive path and takes one aligned character per enabled clock. It accepts the 8b/10b data characters and the twelve standard control characters. It keeps the running disparity from character to character and raises an error flag when a character is outside the code or breaks the disparity rule. On request it removes the K28.5 idle character from the output stream, so that later stages never see it.

A character given with the enable high is sampled on one clock edge. Its byte, its control flag and its error flag appear on the outputs after that edge, qualified by a valid strobe. The running disparity is brought out as a port, so a link monitor or a bench can follow the state that the disparity check depends on.

Top module: `line_dec8b10b`

## Requirements
- R1: The input bit order is din_i[9:4] = abcdei (a in bit 9) and din_i[3:0] = fghj (f in bit 3). A character sampled with en_i high on clock edge n is reported on the outputs after edge n, with vld_o high during the cycle that follows.
- R2: A valid data character D.x.y decodes to byte_o = {y[2:0], x[4:0]}, with ctrl_o and err_o both low.
- R3: The twelve control characters decode with ctrl_o high and err_o low. These are K28.0 to K28.7 (byte 8'h1C + 32*y) and K23.7, K27.7, K29.7 and K30.7 (8'hF7, 8'hFB, 8'hFD, 8'hFE), each in both disparity forms.
- R4: A character whose 6-bit or 4-bit sub-block is in neither table raises err_o (for example abcdei = 111100, or fghj = 0000). byte_o may then carry any value.
- R5: The reserved error words 10'b0000000000 and 10'b1111111111 always raise err_o.
- R6: A pattern that resembles a control character but is not one of the twelve raises err_o with ctrl_o low. This covers K28 heads (001111 or 110000) followed by a tail outside the K28 set, and the alternate tails 0111 or 1000 placed where the run-length rule does not call for them.
- R7: A sub-block with more ones than zeros while the running disparity is positive raises err_o, and so does one with fewer ones while it is negative. The neutral patterns 111000 and 1100 are allowed only at negative disparity, and 000111 and 0011 only at positive.
- R8: rd_o is 0 (negative) after reset. After each enabled character it is updated per sub-block, including errored characters: more ones sets it to 1, fewer ones sets it to 0, and a balanced sub-block leaves it unchanged.
- R9: While idle_del_i is high, a K28.5 character (0011111010 or 1100000101) produces no vld_o, but it still updates rd_o. Other control characters still pass, and with idle_del_i low K28.5 passes as byte 8'hBC.
- R10: While en_i is low the input word is ignored: vld_o is low in the following cycle and rd_o holds its value.
- R11: ctrl_o is never high in the same output cycle as err_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Character present on din_i this cycle |
| din_i | input | 10 | Received character, abcdei in [9:4], fghj in [3:0] |
| idle_del_i | input | 1 | Remove K28.5 characters from the output stream |
| byte_o | output | 8 | Decoded byte, HGF in [7:5], EDCBA in [4:0] |
| ctrl_o | output | 1 | Decoded character is one of the twelve control codes |
| err_o | output | 1 | Code or disparity violation on the decoded character |
| rd_o | output | 1 | Running disparity, 1 = positive |
| vld_o | output | 1 | Output fields carry a decoded character |

## Verification
The bench builds the block with its defaults: idle deletion present (IDLE_DROP_EN = 1) and a negative reset disparity (RD_INIT = 0). This puts the deletion path within reach, including its effect on the disparity state when a character is dropped. It also lets an encoder model written inside the bench send every byte value from a known starting polarity. Forcing either polarity with a disparity-flipping filler byte reaches both forms of each control code, plus the wrong-polarity cases that the error checks need.

// File: rtl/l8b10b_pkg.sv
`timescale 1ns/1ps
package l8b10b_pkg;

  localparam int SYM_W  = 10;
  localparam int HEAD_W = 6;
  localparam int TAIL_W = SYM_W - HEAD_W;
  localparam int BYTE_W = 8;

  localparam logic [SYM_W-1:0] IDLE_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] IDLE_POS = 10'b1100000101;

  typedef struct packed {
    logic       ok;
    logic [4:0] val;
  } head_dec_t;

  typedef struct packed {
    logic       ok;
    logic [2:0] val;
  } tail_dec_t;

  // 6-bit head (abcdei) to the low five bits, both polarities
  function automatic head_dec_t dec_head(input logic [HEAD_W-1:0] h);
    head_dec_t r;
    r = {1'b1, 5'd0};
    case (h)
      6'b100111, 6'b011000: r.val = 5'd0;
      6'b011101, 6'b100010: r.val = 5'd1;
      6'b101101, 6'b010010: r.val = 5'd2;
      6'b110001:            r.val = 5'd3;
      6'b110101, 6'b001010: r.val = 5'd4;
      6'b101001:            r.val = 5'd5;
      6'b011001:            r.val = 5'd6;
      6'b111000, 6'b000111: r.val = 5'd7;
      6'b111001, 6'b000110: r.val = 5'd8;
      6'b100101:            r.val = 5'd9;
      6'b010101:            r.val = 5'd10;
      6'b110100:            r.val = 5'd11;
      6'b001101:            r.val = 5'd12;
      6'b101100:            r.val = 5'd13;
      6'b011100:            r.val = 5'd14;
      6'b010111, 6'b101000: r.val = 5'd15;
      6'b011011, 6'b100100: r.val = 5'd16;
      6'b100011:            r.val = 5'd17;
      6'b010011:            r.val = 5'd18;
      6'b110010:            r.val = 5'd19;
      6'b001011:            r.val = 5'd20;
      6'b101010:            r.val = 5'd21;
      6'b011010:            r.val = 5'd22;
      6'b111010, 6'b000101: r.val = 5'd23;
      6'b110011, 6'b001100: r.val = 5'd24;
      6'b100110:            r.val = 5'd25;
      6'b010110:            r.val = 5'd26;
      6'b110110, 6'b001001: r.val = 5'd27;
      6'b001110, 6'b001111, 6'b110000: r.val = 5'd28;
      6'b101110, 6'b010001: r.val = 5'd29;
      6'b011110, 6'b100001: r.val = 5'd30;
      6'b101011, 6'b010100: r.val = 5'd31;
      default:              r = {1'b0, 5'd0};
    endcase
    return r;
  endfunction

  // 4-bit tail (fghj) to the high three bits, both polarities and alternates
  function automatic tail_dec_t dec_tail(input logic [TAIL_W-1:0] t);
    tail_dec_t r;
    r = {1'b1, 3'd0};
    case (t)
      4'b0100, 4'b1011:                   r.val = 3'd0;
      4'b1001:                            r.val = 3'd1;
      4'b0101:                            r.val = 3'd2;
      4'b1100, 4'b0011:                   r.val = 3'd3;
      4'b1101, 4'b0010:                   r.val = 3'd4;
      4'b1010:                            r.val = 3'd5;
      4'b0110:                            r.val = 3'd6;
      4'b1110, 4'b0001, 4'b0111, 4'b1000: r.val = 3'd7;
      default:                            r = {1'b0, 3'd0};
    endcase
    return r;
  endfunction

  // tails allowed after a K28 head, written in its negative-start form
  function automatic logic k28_tail_ok(input logic [TAIL_W-1:0] t);
    return (t == 4'b0100) || (t == 4'b1001) || (t == 4'b0101) || (t == 4'b0011) ||
           (t == 4'b0010) || (t == 4'b1010) || (t == 4'b0110) || (t == 4'b1000);
  endfunction

  // run-length rule for the two encodings of y = 7 in data characters
  function automatic logic data_tail_ok(input logic [TAIL_W-1:0] t, input logic [1:0] ei);
    logic ok;
    ok = 1'b1;
    if (t == 4'b0111) ok = (ei == 2'b11);
    if (t == 4'b1000) ok = (ei == 2'b00);
    if (t == 4'b1110) ok = (ei != 2'b11);
    if (t == 4'b0001) ok = (ei != 2'b00);
    return ok;
  endfunction

  // K23.7, K27.7, K29.7, K30.7 in both polarities
  function automatic logic kx7_match(input logic [HEAD_W-1:0] h, input logic [TAIL_W-1:0] t);
    logic neg_head, pos_head;
    neg_head = (h == 6'b111010) || (h == 6'b110110) || (h == 6'b101110) || (h == 6'b011110);
    pos_head = (h == 6'b000101) || (h == 6'b001001) || (h == 6'b010001) || (h == 6'b100001);
    return (neg_head && (t == 4'b1000)) || (pos_head && (t == 4'b0111));
  endfunction

endpackage

// File: rtl/l8b10b_symbol_map.sv
`timescale 1ns/1ps
module l8b10b_symbol_map
  import l8b10b_pkg::*;
(
  input  logic [SYM_W-1:0]  sym_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ctrl_o,
  output logic              code_err_o,
  output logic              idle_o
);

  logic [HEAD_W-1:0] head;
  logic [TAIL_W-1:0] tail_raw;
  logic [TAIL_W-1:0] tail_n;
  logic              k28_head;
  logic              kx7_hit;
  head_dec_t         hd;
  tail_dec_t         td;

  assign head     = sym_i[SYM_W-1:TAIL_W];
  assign tail_raw = sym_i[TAIL_W-1:0];
  assign k28_head = (head == 6'b001111) || (head == 6'b110000);
  // the positive K28 forms are full complements; fold them onto the negative form
  assign tail_n   = (head == 6'b110000) ? ~tail_raw : tail_raw;
  assign kx7_hit  = kx7_match(head, tail_raw);
  assign hd       = dec_head(head);
  assign td       = dec_tail(tail_n);
  assign byte_o   = {td.val, hd.val};
  assign idle_o   = (sym_i == IDLE_NEG) || (sym_i == IDLE_POS);

  always_comb begin
    if (k28_head) begin
      ctrl_o     = k28_tail_ok(tail_n);
      code_err_o = ~k28_tail_ok(tail_n);
    end else if (kx7_hit) begin
      ctrl_o     = 1'b1;
      code_err_o = 1'b0;
    end else begin
      ctrl_o     = 1'b0;
      code_err_o = ~(hd.ok && td.ok && data_tail_ok(tail_raw, head[1:0]));
    end
  end

endmodule

// File: rtl/l8b10b_disp_track.sv
`timescale 1ns/1ps
module l8b10b_disp_track
  import l8b10b_pkg::*;
#(
  parameter logic RD_INIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             rd_o,
  output logic             viol_o
);

  logic [HEAD_W-1:0] head;
  logic [TAIL_W-1:0] tail;
  logic [2:0]        n_head;
  logic [2:0]        n_tail;
  logic              rd_q, rd_mid, rd_nxt;
  logic              head_hi, head_lo, tail_hi, tail_lo;
  logic              head_bad, tail_bad;

  assign head   = sym_i[SYM_W-1:TAIL_W];
  assign tail   = sym_i[TAIL_W-1:0];
  assign n_head = 3'($countones(head));
  assign n_tail = 3'($countones(tail));

  always_comb begin
    head_hi  = n_head > 3'd3;
    head_lo  = n_head < 3'd3;
    head_bad = (head_hi & rd_q) | (head_lo & ~rd_q) |
               ((head == 6'b111000) & rd_q) | ((head == 6'b000111) & ~rd_q);
    rd_mid   = head_hi ? 1'b1 : (head_lo ? 1'b0 : rd_q);

    tail_hi  = n_tail > 3'd2;
    tail_lo  = n_tail < 3'd2;
    tail_bad = (tail_hi & rd_mid) | (tail_lo & ~rd_mid) |
               ((tail == 4'b1100) & rd_mid) | ((tail == 4'b0011) & ~rd_mid);
    rd_nxt   = tail_hi ? 1'b1 : (tail_lo ? 1'b0 : rd_mid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= RD_INIT;
    else if (step_i) rd_q <= rd_nxt;
  end

  assign rd_o   = rd_q;
  assign viol_o = head_bad | tail_bad;

endmodule

// File: rtl/line_dec8b10b.sv
`timescale 1ns/1ps
module line_dec8b10b
  import l8b10b_pkg::*;
#(
  parameter bit   IDLE_DROP_EN = 1'b1,
  parameter logic RD_INIT      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [SYM_W-1:0]  din_i,
  input  logic              idle_del_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ctrl_o,
  output logic              err_o,
  output logic              rd_o,
  output logic              vld_o
);

  logic [BYTE_W-1:0] map_byte;
  logic              map_ctrl;
  logic              code_err;
  logic              idle_hit;
  logic              disp_viol;
  logic              drop_now;
  logic              accept;
  logic              err_now;

  l8b10b_symbol_map u_map (
    .sym_i      (din_i),
    .byte_o     (map_byte),
    .ctrl_o     (map_ctrl),
    .code_err_o (code_err),
    .idle_o     (idle_hit)
  );

  l8b10b_disp_track #(.RD_INIT(RD_INIT)) u_disp (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (en_i),
    .sym_i  (din_i),
    .rd_o   (rd_o),
    .viol_o (disp_viol)
  );

  generate
    if (IDLE_DROP_EN) begin : g_idle_drop
      assign drop_now = idle_del_i & idle_hit;
    end else begin : g_idle_keep
      assign drop_now = 1'b0;
    end
  endgenerate

  assign accept  = en_i & ~drop_now;
  assign err_now = code_err | disp_viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      byte_o <= '0;
      ctrl_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      vld_o <= accept;
      if (accept) begin
        byte_o <= map_byte;
        ctrl_o <= map_ctrl & ~err_now;
        err_o  <= err_now;
      end
    end
  end

endmodule

// File: rtl/line_dec8b10b_chk.sv
`timescale 1ns/1ps
module line_dec8b10b_chk #(
  parameter bit IDLE_DROP_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic [9:0] din_i,
  input logic       idle_del_i,
  input logic [7:0] byte_o,
  input logic       ctrl_o,
  input logic       err_o,
  input logic       rd_o,
  input logic       vld_o,
  input logic       disp_viol
);

  logic is_idle_in;
  assign is_idle_in = (din_i == 10'b0011111010) || (din_i == 10'b1100000101);

  // R10: a cycle without enable yields no output in the next cycle
  a_r10_no_vld_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !vld_o);

  // R10: running disparity holds while enable is low
  a_r10_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(rd_o));

  // R5: the reserved error words are reported as errors
  a_r5_reserved_word: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && ((din_i == 10'b0000000000) || (din_i == 10'b1111111111)) |=> vld_o && err_o);

  // R9: K28.5 is suppressed while deletion is requested
  a_r9_idle_removed: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && IDLE_DROP_EN && idle_del_i && is_idle_in |=> !vld_o);

  // R7: a disparity violation found by the tracker reaches the error output
  a_r7_disp_to_err: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && disp_viol && !(IDLE_DROP_EN && idle_del_i && is_idle_in) |=> err_o);

  // R3: a control indication always carries one of the twelve byte values
  a_r3_ctrl_byte_legal: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && ctrl_o |-> (byte_o[4:0] == 5'd28) ||
      ((byte_o[7:5] == 3'd7) && ((byte_o[4:0] == 5'd23) || (byte_o[4:0] == 5'd27) ||
                                 (byte_o[4:0] == 5'd29) || (byte_o[4:0] == 5'd30))));

  // R11: control and error are never reported together
  a_r11_ctrl_excludes_err: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && ctrl_o |-> !err_o);

endmodule

bind line_dec8b10b line_dec8b10b_chk #(.IDLE_DROP_EN(IDLE_DROP_EN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .din_i      (din_i),
  .idle_del_i (idle_del_i),
  .byte_o     (byte_o),
  .ctrl_o     (ctrl_o),
  .err_o      (err_o),
  .rd_o       (rd_o),
  .vld_o      (vld_o),
  .disp_viol  (disp_viol)
);

// File: tb/line_dec8b10b_tb.sv
`timescale 1ns/1ps
module line_dec8b10b_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       idel = 1'b0;
  logic [9:0] din = '0;
  logic [7:0] byte_o;
  logic       ctrl_o, err_o, rd_o, vld_o;

  always #2 clk = ~clk;

  line_dec8b10b u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .din_i(din), .idle_del_i(idel),
    .byte_o(byte_o), .ctrl_o(ctrl_o), .err_o(err_o), .rd_o(rd_o), .vld_o(vld_o)
  );

  typedef struct {
    bit       vld;
    bit [7:0] b;
    bit       chk_b;
    bit       ctrl;
    bit       chk_c;
    bit       err;
    bit       rd;
    string    req;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   exp_rd = 1'b0;
  bit   finished = 1'b0;

  // ---------------- reference encoder ----------------
  function automatic bit [5:0] head_neg(input bit [4:0] x);
    case (x)
      5'd0: return 6'b100111;  5'd1: return 6'b011101;  5'd2: return 6'b101101;
      5'd3: return 6'b110001;  5'd4: return 6'b110101;  5'd5: return 6'b101001;
      5'd6: return 6'b011001;  5'd7: return 6'b111000;  5'd8: return 6'b111001;
      5'd9: return 6'b100101;  5'd10: return 6'b010101; 5'd11: return 6'b110100;
      5'd12: return 6'b001101; 5'd13: return 6'b101100; 5'd14: return 6'b011100;
      5'd15: return 6'b010111; 5'd16: return 6'b011011; 5'd17: return 6'b100011;
      5'd18: return 6'b010011; 5'd19: return 6'b110010; 5'd20: return 6'b001011;
      5'd21: return 6'b101010; 5'd22: return 6'b011010; 5'd23: return 6'b111010;
      5'd24: return 6'b110011; 5'd25: return 6'b100110; 5'd26: return 6'b010110;
      5'd27: return 6'b110110; 5'd28: return 6'b001110; 5'd29: return 6'b101110;
      5'd30: return 6'b011110; default: return 6'b101011;
    endcase
  endfunction

  function automatic bit [3:0] tail_neg(input bit [2:0] y);
    case (y)
      3'd0: return 4'b1011; 3'd1: return 4'b1001; 3'd2: return 4'b0101; 3'd3: return 4'b1100;
      3'd4: return 4'b1101; 3'd5: return 4'b1010; 3'd6: return 4'b0110; default: return 4'b1110;
    endcase
  endfunction

  function automatic bit [3:0] k28_tail(input bit [2:0] y);
    case (y)
      3'd0: return 4'b0100; 3'd1: return 4'b1001; 3'd2: return 4'b0101; 3'd3: return 4'b0011;
      3'd4: return 4'b0010; 3'd5: return 4'b1010; 3'd6: return 4'b0110; default: return 4'b1000;
    endcase
  endfunction

  // disparity rule of R8
  function automatic bit next_rd(input bit rd, input bit [9:0] w);
    int h, t;
    bit m;
    h = $countones(w[9:4]);
    t = $countones(w[3:0]);
    m = (h > 3) ? 1'b1 : ((h < 3) ? 1'b0 : rd);
    return (t > 2) ? 1'b1 : ((t < 2) ? 1'b0 : m);
  endfunction

  function automatic bit [9:0] enc(input bit [7:0] b, input bit k, input bit rd);
    bit [4:0] x;
    bit [2:0] y;
    bit [5:0] h;
    bit [3:0] t;
    bit       rm;
    x = b[4:0];
    y = b[7:5];
    if (k && x == 5'd28) begin
      return rd ? ~{6'b001111, k28_tail(y)} : {6'b001111, k28_tail(y)};
    end
    h = head_neg(x);
    if (rd && ($countones(h) != 3 || h == 6'b111000)) h = ~h;
    rm = ($countones(h) > 3) ? 1'b1 : (($countones(h) < 3) ? 1'b0 : rd);
    if (k) begin
      t = rm ? 4'b1000 : 4'b0111;
    end else begin
      t = tail_neg(y);
      if (y == 3'd7 && ((!rm && h[1:0] == 2'b11) || (rm && h[1:0] == 2'b00))) t = 4'b0111;
      if (rm && ($countones(t) != 2 || t == 4'b1100)) t = ~t;
    end
    return {h, t};
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk_bit(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic chk_byte(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s byte: got %02h expected %02h", req, got, exp);
    end
  endtask

  // ---------------- driver ----------------
  task automatic drive(input bit [9:0] w, input bit e, input bit id, input bit ev,
                       input bit chkb, input bit [7:0] b, input bit ec, input bit chkc,
                       input bit ee, input string req);
    exp_t x;
    @(negedge clk);
    din = w; en = e; idel = id;
    if (e) exp_rd = next_rd(exp_rd, w);
    x.vld = ev; x.b = b; x.chk_b = chkb; x.ctrl = ec; x.chk_c = chkc;
    x.err = ee; x.rd = exp_rd; x.req = req;
    sbq.push_back(x);
  endtask

  task automatic send_char(input bit [7:0] b, input bit k, input string req);
    drive(enc(b, k, exp_rd), 1'b1, 1'b0, 1'b1, 1'b1, b, k, 1'b1, 1'b0, req);
  endtask

  task automatic send_bad(input bit [9:0] w, input string req);
    drive(w, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, req);
  endtask

  // D.0.1 flips the disparity from either side
  task automatic force_rd(input bit p);
    if (exp_rd != p) send_char(8'h20, 1'b0, "R8");
  endtask

  // ---------------- monitor ----------------
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk_bit(e.req, "vld", vld_o, e.vld);
        if (e.vld) begin
          chk_bit(e.req, "err", err_o, e.err);
          if (e.chk_c) chk_bit(e.req, "ctrl", ctrl_o, e.ctrl);
          if (e.chk_b) chk_byte(e.req, byte_o, e.b);
        end
        chk_bit(e.req, "rd", rd_o, e.rd);
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  bit [7:0] klist [12];

  initial begin
    klist = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
              8'hF7, 8'hFB, 8'hFD, 8'hFE};
    repeat (3) @(posedge clk);
    #1;
    chk_bit("R8", "reset vld", vld_o, 1'b0);
    chk_bit("R8", "reset rd", rd_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R2: every data byte, twice, in a scattered order
    for (int i = 0; i < 512; i++) send_char(8'((i * 37 + 11) % 256), 1'b0, "R2");

    // R3: all twelve control codes from both polarities
    for (int j = 0; j < 12; j++) begin
      for (int p = 0; p < 2; p++) begin
        force_rd(p[0]);
        send_char(klist[j], 1'b1, "R3");
      end
    end

    // R7: disparity violations
    force_rd(1'b0);
    send_bad(10'b1100000101, "R7");
    force_rd(1'b1);
    send_bad(10'b0011111010, "R7");
    force_rd(1'b0);
    send_bad(10'b0001110100, "R7");
    force_rd(1'b1);
    send_bad(10'b1100011100, "R7");

    // R4: sub-blocks outside the tables
    send_bad(10'b1111000101, "R4");
    send_bad(10'b1100010000, "R4");

    // R5: reserved error words
    send_bad(10'b0000000000, "R5");
    send_bad(10'b1111111111, "R5");

    // R6: control look-alikes
    force_rd(1'b0);
    send_bad(10'b0011110001, "R6");
    force_rd(1'b0);
    send_bad(10'b1001010111, "R6");
    force_rd(1'b1);
    send_bad(~10'b0011110001, "R6");

    // recovery after errors
    send_char(8'h4A, 1'b0, "R2");
    send_char(8'hE0, 1'b0, "R2");

    // R9: idle deletion
    force_rd(1'b0);
    drive(enc(8'hBC, 1'b1, exp_rd), 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9");
    force_rd(1'b1);
    drive(enc(8'hBC, 1'b1, exp_rd), 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9");
    drive(enc(8'h3C, 1'b1, exp_rd), 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, "R9");
    send_char(8'h15, 1'b0, "R9");
    send_char(8'hBC, 1'b1, "R9");

    // R10: enable low ignores the word
    force_rd(1'b1);
    drive(10'b1111111111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R10");
    drive(10'b0000000000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R10");
    send_char(8'h7E, 1'b0, "R10");

    // R1: quiet tail, no outputs
    for (int q = 0; q < 3; q++)
      drive(10'b0011111010, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1");

    wait (sbq.size() == 0);
    @(posedge clk);
    #2;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule